// File: doc/BRIEF.md
# Pushbutton Soft/Hard Reset Controller

This block watches one active-low pushbutton input and decides, from how long the button is held, which of two resets to request. A short press produces a narrow active-low soft-reset pulse. The pulse appears only after the button has been released and a settling delay has passed. A hold that lasts past the long-hold limit raises a hard-reset request instead. The request stays up for as long as the button stays down, and an external reset generator adds its own tail after it drops.

The raw input goes through two synchronizing flops. It is also caught by a flop with an asynchronous set, so a press narrower than one clock period still counts. The state machine clears that capture flop once it has seen the press. Three parameters, counted in clock cycles, set the long-hold limit, the settling delay and the pulse width. A bench can therefore run with short values.

Top module: `pbtn_reset_ctrl`

## Requirements
- R1: While reset is applied and directly after it, `soft_rst_n` is 1 and `hard_req` is 0.
- R2: A press that the block sees for fewer than LONG_CYC cycles produces exactly one soft pulse after release, and no soft pulse starts while the button is seen as held.
- R3: Let D be the number of rising clock edges at which the button is low, with a minimum of 3 (see R7). Counting the first edge after the button falls as edge 1, the soft pulse goes low at edge D+4+DB_CYC.
- R4: The soft pulse stays low for exactly SOFT_CYC cycles.
- R5: If D is at least LONG_CYC, `hard_req` rises at edge LONG_CYC+3 and stays high through edge D+3. It therefore stays high for D-LONG_CYC+1 cycles, dropping one edge after the released button is seen.
- R6: A press with D of at least LONG_CYC produces no soft pulse.
- R7: A low pulse on `btn_n` that is narrower than a clock period and falls between two edges is treated as a press with D = 3.
- R8: A new press during the settling delay cancels the pending pulse. Exactly one pulse follows, timed by R3 from the new press.
- R9: A new press during a soft pulse ends that pulse at edge 3 of the new press. A full pulse then follows the new release.
- R10: With the button idle high, neither output ever becomes active.
- R11: `soft_rst_n` low and `hard_req` high never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Raw pushbutton, low when pressed, asynchronous |
| soft_rst_n | output | 1 | Soft-reset pulse, active low, registered |
| hard_req | output | 1 | Hard-reset request, active high, registered |

## Verification
Every result is tied to an edge count measured from the first rising edge after the stimulus. Two edges are spent in the synchronizer and one on entering the press state. The soft pulse is due at edge D+4+DB_CYC. The hard request is due at edge LONG_CYC+3 and ends after edge D+3. A pulse cut short by a new press is due high at edge 3. The bench counts rising edges and samples the outputs at the following falling edge. It records the edge index of every output change relative to the press and compares that index with these formulas. It sweeps D over every value from a sub-cycle glitch to past the long-hold limit.

// File: rtl/pbtn_pkg.sv
// Shared types for the pushbutton reset controller.
package pbtn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESSED,
        ST_LONG,
        ST_DEBOUNCE,
        ST_PULSE
    } pb_state_t;
endpackage

// File: rtl/pbtn_capture.sv
// Press capture: a flop with an asynchronous set holds any low level or
// glitch on btn_n. A synchronizer chain then carries it into the clock domain.
// Assumes clr is driven from registered state in the clk domain.
module pbtn_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic clr,
    output logic press_s
);
    logic                   caught;
    logic [SYNC_STAGES-1:0] sync_q;

    // Set at once by a low button, cleared on a clock edge once acknowledged.
    always_ff @(posedge clk or negedge btn_n) begin
        if (!btn_n)
            caught <= 1'b1;
        else if (!rst_n || clr)
            caught <= 1'b0;
    end

    // Bring the captured level into the clock domain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= caught;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], caught};
            end
        end
    endgenerate

    assign press_s = sync_q[SYNC_STAGES-1];

    // A button seen low at an edge leaves the capture flop set.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_n |=> caught);
endmodule

// File: rtl/pbtn_fsm.sv
// Press classifier: times a synchronized press, then issues a soft pulse
// after release and settling, or a hard request while a long hold lasts.
// Assumes press_s is already synchronous to clk.
module pbtn_fsm
    import pbtn_pkg::*;
#(
    parameter int LONG_CYC = 200_000_000,
    parameter int DB_CYC   = 2_000_000,
    parameter int SOFT_CYC = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic press_s,
    output logic clr,
    output logic soft_rst_n,
    output logic hard_req
);
    localparam int MAX_AB  = (LONG_CYC > DB_CYC) ? LONG_CYC : DB_CYC;
    localparam int MAX_CYC = (MAX_AB > SOFT_CYC) ? MAX_AB : SOFT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pb_state_t          state, state_nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt;
    logic [CNT_W-1:0]   low_run;

    // Next-state and interval counter logic.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt + 1'b1;
        case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (press_s) state_nxt = ST_PRESSED;
            end
            ST_PRESSED: begin
                if (!press_s) begin
                    state_nxt = ST_DEBOUNCE;
                    cnt_nxt   = '0;
                end else if (cnt == CNT_W'(LONG_CYC - 1)) begin
                    state_nxt = ST_LONG;
                    cnt_nxt   = '0;
                end
            end
            ST_LONG: begin
                cnt_nxt = '0;
                if (!press_s) state_nxt = ST_IDLE;
            end
            ST_DEBOUNCE: begin
                if (press_s) begin
                    state_nxt = ST_PRESSED;
                    cnt_nxt   = '0;
                end else if (cnt == CNT_W'(DB_CYC - 1)) begin
                    state_nxt = ST_PULSE;
                    cnt_nxt   = '0;
                end
            end
            ST_PULSE: begin
                if (press_s) begin
                    state_nxt = ST_PRESSED;
                    cnt_nxt   = '0;
                end else if (cnt == CNT_W'(SOFT_CYC - 1)) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State, counter and glitch-free registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            soft_rst_n <= 1'b1;
            hard_req   <= 1'b0;
        end else begin
            state      <= state_nxt;
            cnt        <= cnt_nxt;
            soft_rst_n <= (state_nxt != ST_PULSE);
            hard_req   <= (state_nxt == ST_LONG);
        end
    end

    // Acknowledge the capture flop once a press has been taken.
    assign clr = (state == ST_PRESSED) || (state == ST_LONG);

    // Checker support: length of the current low run of the soft output.
    always_ff @(posedge clk) begin
        if (!rst_n)           low_run <= '0;
        else if (!soft_rst_n) low_run <= low_run + 1'b1;
        else                  low_run <= '0;
    end

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!soft_rst_n && hard_req));
    assert_soft_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst_n) |-> !$past(press_s));
    assert_hard_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_req && !press_s) |=> !hard_req);
    assert_hard_needs_press_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_req) |-> $past(press_s));
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= CNT_W'(SOFT_CYC));
endmodule

// File: rtl/pbtn_reset_ctrl.sv
// Top: pushbutton soft/hard reset controller. btn_n may be asynchronous.
// All intervals are in clk cycles.
module pbtn_reset_ctrl #(
    parameter int LONG_CYC    = 200_000_000,
    parameter int DB_CYC      = 2_000_000,
    parameter int SOFT_CYC    = 10_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic soft_rst_n,
    output logic hard_req
);
    logic press_s;
    logic clr;

    pbtn_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (btn_n),
        .clr     (clr),
        .press_s (press_s)
    );

    pbtn_fsm #(
        .LONG_CYC (LONG_CYC),
        .DB_CYC   (DB_CYC),
        .SOFT_CYC (SOFT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .press_s    (press_s),
        .clr        (clr),
        .soft_rst_n (soft_rst_n),
        .hard_req   (hard_req)
    );
endmodule

// File: tb/test_pbtn_reset_ctrl.sv
module test_pbtn_reset_ctrl;
    localparam int LONG = 40;
    localparam int DB   = 12;
    localparam int SOFT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic soft_rst_n;
    logic hard_req;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    pbtn_reset_ctrl #(.LONG_CYC(LONG), .DB_CYC(DB), .SOFT_CYC(SOFT)) i_pbtn_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
        .soft_rst_n(soft_rst_n), .hard_req(hard_req)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor, sampled at falling edges.
    int  base = 0;
    int  soft_falls, soft_fall_rel, soft_run, soft_last_w;
    int  hard_rise_rel, hard_cnt;
    logic soft_prev = 1'b1;
    logic hard_prev = 1'b0;

    task automatic mon_clear();
        soft_falls = 0; soft_fall_rel = -1; soft_run = 0; soft_last_w = -1;
        hard_rise_rel = -1; hard_cnt = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!soft_rst_n && soft_prev) begin
                soft_falls++;
                soft_fall_rel = cyc - base;
                soft_run = 0;
            end
            if (!soft_rst_n) soft_run++;
            if (soft_rst_n && !soft_prev) soft_last_w = soft_run;
            if (hard_req && !hard_prev) hard_rise_rel = cyc - base;
            if (hard_req) hard_cnt++;
        end
        soft_prev = soft_rst_n;
        hard_prev = hard_req;
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a press of d low edges (d == 0: sub-cycle glitch), starting at a falling edge.
    task automatic press(int d);
        @(negedge clk);
        base = cyc;
        btn_n = 1'b0;
        if (d == 0) begin
            #1 btn_n = 1'b1;
        end else begin
            repeat (d) @(negedge clk);
            btn_n = 1'b1;
        end
    endtask

    task automatic settle();
        repeat (DB + SOFT + 14) @(negedge clk);
    endtask

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        chk("R1 soft in reset", int'(soft_rst_n), 1);
        chk("R1 hard in reset", int'(hard_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 soft after reset", int'(soft_rst_n), 1);
        chk("R1 hard after reset", int'(hard_req), 0);

        // R10: idle input gives no activity
        mon_clear();
        repeat (30) @(negedge clk);
        chk("R10 idle soft", soft_falls, 0);
        chk("R10 idle hard", hard_cnt, 0);

        // Sweep press length from glitch to beyond long hold
        for (int d = 0; d <= LONG + 4; d++) begin
            int de;
            de = (d < 3) ? 3 : d;
            mon_clear();
            press(d);
            settle();
            if (d < LONG) begin
                chk(d == 0 ? "R7 glitch pulse count" : "R2 pulse count", soft_falls, 1);
                chk("R3 pulse start edge", soft_fall_rel, de + 4 + DB);
                chk("R4 pulse width", soft_last_w, SOFT);
                chk("R11 no hard on short press", hard_cnt, 0);
            end else begin
                chk("R6 no soft after long", soft_falls, 0);
                chk("R5 hard rise edge", hard_rise_rel, LONG + 3);
                chk("R5 hard width", hard_cnt, d - LONG + 1);
            end
        end

        // R8: re-press during settling delay
        mon_clear();
        press(5);
        repeat (6) @(negedge clk);
        press(5);
        settle();
        chk("R8 single pulse", soft_falls, 1);
        chk("R8 timing from new press", soft_fall_rel, 5 + 4 + DB);
        chk("R8 width", soft_last_w, SOFT);

        // R9: re-press during the pulse
        mon_clear();
        press(5);
        while (soft_rst_n) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        base = cyc;
        btn_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 still low at edge 2", int'(soft_rst_n), 0);
        @(negedge clk);
        chk("R9 cut at edge 3", int'(soft_rst_n), 1);
        repeat (2) @(negedge clk);
        btn_n = 1'b1;
        settle();
        chk("R9 two pulses", soft_falls, 2);
        chk("R9 new pulse edge", soft_fall_rel, 5 + 4 + DB);
        chk("R9 new pulse width", soft_last_w, SOFT);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule